// File: doc/BRIEF.md
# Serial Programming Mode Entry Detector

This block watches a two-wire serial programming port, a clock line and a data line, together with the reset pin and a high-voltage detect level. It decides when the device enters programming mode, reports whether it is in that mode, and reports which entry path was taken. Both port lines are synchronised into the system clock domain. A rising edge of the port clock samples the data line.

There are two entry paths. A high-voltage level is always accepted and overrides everything else. The low-voltage path works only while a persistent low-voltage-enable bit is set. It also needs the reset pin held active while an exact key of `KEY_BITS` bits is shifted in, most significant bit first. A wrong key parks the block until the reset pin is released and asserted again. The enable bit powers up set. It can be cleared once, and only while the block is in high-voltage mode. In low-voltage mode the reset pin is forced to act as a reset and is masked from general-purpose reads.

Top module: `pe_entry_detect`

## Requirements
- R1: After `rst_n` is deasserted, `prog_active_o`, `via_hv_o`, `via_lv_o` and `pin_forced_reset_o` are 0 and `lv_enable_o` is 1.
- R2: While `hv_detect_i` is 1, the block is in high-voltage mode (`prog_active_o`=1, `via_hv_o`=1, `via_lv_o`=0) from the next cycle on, whatever the value of `lv_enable_o`.
- R3: With `lv_enable_o`=1 and `mclr_n_i` held at 0, exactly `KEY_BITS` port-clock rising edges are needed. Each edge samples `pdat_i`, and the first bit is the key's MSb. If the bits equal `ENTRY_KEY`, the block is in low-voltage mode (`prog_active_o`=1, `via_lv_o`=1) a few cycles after the last edge.
- R4: If the shifted key does not match, the block stays out of programming mode. Further port-clock edges have no effect until `mclr_n_i` goes to 1 and back to 0.
- R5: Releasing `mclr_n_i` before all key bits have arrived discards the partial key. The next attempt needs a full fresh key.
- R6: While `lv_enable_o` is 0, no key sequence enters programming mode.
- R7: `lock_req_i` clears `lv_enable_o` only while in high-voltage mode. Otherwise it is ignored. Nothing sets the bit again except `rst_n`.
- R8: Low-voltage mode ends on the cycle after `mclr_n_i` returns to 1. High-voltage mode ends on the cycle after `hv_detect_i` returns to 0. Both clear `prog_active_o`.
- R9: `pin_forced_reset_o` is 1 exactly while in low-voltage mode.
- R10: Raising `hv_detect_i` during a key shift, after a rejected key or in low-voltage mode moves the block to high-voltage mode.
- R11: `via_hv_o` and `via_lv_o` are never both 1, and `prog_active_o` is 1 exactly when one of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hv_detect_i | input | 1 | High-voltage level present on the reset pin |
| mclr_n_i | input | 1 | Reset pin, active low |
| pclk_i | input | 1 | Programming port clock (asynchronous) |
| pdat_i | input | 1 | Programming port data (asynchronous) |
| lock_req_i | input | 1 | Request to clear the low-voltage-enable bit |
| prog_active_o | output | 1 | Programming mode active |
| via_hv_o | output | 1 | Entry was through the high-voltage path |
| via_lv_o | output | 1 | Entry was through the low-voltage key path |
| lv_enable_o | output | 1 | Persistent low-voltage-enable bit |
| pin_forced_reset_o | output | 1 | Reset pin forced to reset function, input read masked |

## Verification
On every cycle, the assertions check that the path flags exclude each other and agree with the active flag. They also check that the high-voltage level always wins on the following cycle, that the enable bit never rises and falls only from high-voltage mode, that low-voltage mode begins only with the pin held low and the bit set, and that releasing the pin ends that mode. The bench scenarios cover the parts that depend on sequence history: the exact key length and bit order, the rejection of wrong keys until a fresh reset assertion, the discarding of partial keys, and the lockout that blocks later key attempts.

// File: rtl/pe_pkg.sv
package pe_pkg;
    typedef enum logic [2:0] {
        MODE_IDLE   = 3'd0,
        MODE_ARMED  = 3'd1,
        MODE_REJECT = 3'd2,
        MODE_LV     = 3'd3,
        MODE_HV     = 3'd4
    } mode_t;
endpackage

// File: rtl/pe_sync_edge.sv
module pe_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pclk_i,
    input  logic pdat_i,
    output logic rise_o,
    output logic dat_o
);
    logic [STAGES:0] clk_pipe;
    logic [STAGES:0] dat_pipe;
    logic            last_d, last_q;

    assign clk_pipe[0] = pclk_i;
    assign dat_pipe[0] = pdat_i;

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                clk_pipe[g] <= 1'b0;
                dat_pipe[g] <= 1'b0;
            end else begin
                clk_pipe[g] <= clk_pipe[g-1];
                dat_pipe[g] <= dat_pipe[g-1];
            end
        end
    end

    always_comb begin
        last_d = clk_pipe[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= last_d;
    end

    assign rise_o = clk_pipe[STAGES] & ~last_q;
    assign dat_o  = dat_pipe[STAGES];
endmodule

// File: rtl/pe_key_shifter.sv
module pe_key_shifter #(
    parameter int KEY_BITS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                shift_i,
    input  logic                bit_i,
    output logic                full_o,
    output logic [KEY_BITS-1:0] word_o
);
    localparam int CW = $clog2(KEY_BITS + 1);

    typedef struct packed {
        logic [KEY_BITS-1:0] word;
        logic [CW-1:0]       cnt;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d   = sh_q;
        word_o = {sh_q.word[KEY_BITS-2:0], bit_i};
        full_o = shift_i && (sh_q.cnt == CW'(KEY_BITS - 1));
        if (clr_i) begin
            sh_d.word = '0;
            sh_d.cnt  = '0;
        end else if (shift_i) begin
            sh_d.word = word_o;
            sh_d.cnt  = sh_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/pe_entry_detect.sv
module pe_entry_detect #(
    parameter int                KEY_BITS    = 32,
    parameter logic [KEY_BITS-1:0] ENTRY_KEY = 32'h5A3C_96E1,
    parameter int                SYNC_STAGES = 2,
    parameter bit                LVE_DEFAULT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hv_detect_i,
    input  logic mclr_n_i,
    input  logic pclk_i,
    input  logic pdat_i,
    input  logic lock_req_i,
    output logic prog_active_o,
    output logic via_hv_o,
    output logic via_lv_o,
    output logic lv_enable_o,
    output logic pin_forced_reset_o
);
    import pe_pkg::*;

    typedef struct packed {
        mode_t mode;
        logic  lv_en;
    } st_t;

    st_t st_d, st_q;

    logic                rise;
    logic                sdat;
    logic                key_full;
    logic [KEY_BITS-1:0] key_word;
    logic                shift_clr;
    logic                shift_en;

    pe_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pclk_i (pclk_i),
        .pdat_i (pdat_i),
        .rise_o (rise),
        .dat_o  (sdat)
    );

    pe_key_shifter #(.KEY_BITS(KEY_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (shift_clr),
        .shift_i (shift_en),
        .bit_i   (sdat),
        .full_o  (key_full),
        .word_o  (key_word)
    );

    assign shift_clr = (st_q.mode != MODE_ARMED);
    assign shift_en  = (st_q.mode == MODE_ARMED) && rise;

    always_comb begin
        st_d = st_q;
        if (hv_detect_i) begin
            st_d.mode = MODE_HV;
            if (st_q.mode == MODE_HV && lock_req_i) st_d.lv_en = 1'b0;
        end else begin
            unique case (st_q.mode)
                MODE_IDLE: begin
                    if (!mclr_n_i && st_q.lv_en) st_d.mode = MODE_ARMED;
                end
                MODE_ARMED: begin
                    if (mclr_n_i) st_d.mode = MODE_IDLE;
                    else if (key_full)
                        st_d.mode = (key_word == ENTRY_KEY) ? MODE_LV : MODE_REJECT;
                end
                MODE_REJECT, MODE_LV: begin
                    if (mclr_n_i) st_d.mode = MODE_IDLE;
                end
                MODE_HV: st_d.mode = MODE_IDLE;
                default: st_d.mode = MODE_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= MODE_IDLE;
            st_q.lv_en <= LVE_DEFAULT;
        end else begin
            st_q <= st_d;
        end
    end

    assign via_hv_o           = (st_q.mode == MODE_HV);
    assign via_lv_o           = (st_q.mode == MODE_LV);
    assign prog_active_o      = via_hv_o | via_lv_o;
    assign pin_forced_reset_o = via_lv_o;
    assign lv_enable_o        = st_q.lv_en;
endmodule

// File: rtl/pe_entry_checker.sv
module pe_entry_checker (
    input logic clk,
    input logic rst_n,
    input logic hv_detect_i,
    input logic mclr_n_i,
    input logic prog_active_o,
    input logic via_hv_o,
    input logic via_lv_o,
    input logic lv_enable_o
);
    logic warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= 1'b0;
        else        warm_q <= 1'b1;
    end

    // R11: path flags exclusive and consistent with the active flag
    assert_paths_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({via_hv_o, via_lv_o}) && (prog_active_o == (via_hv_o || via_lv_o)));

    // R2 and R10: high voltage wins on the following cycle
    assert_hv_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q && $past(hv_detect_i) |-> via_hv_o);

    // R7: the enable bit never rises after reset
    assert_lve_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q |-> !$rose(lv_enable_o));

    // R7: the enable bit falls only out of high-voltage mode
    assert_lve_fall_in_hv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q && $fell(lv_enable_o) |-> $past(via_hv_o));

    // R3 and R6: low-voltage mode starts only with pin held low and bit set
    assert_lv_entry_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q && $rose(via_lv_o) |-> ($past(lv_enable_o) && !$past(mclr_n_i)));

    // R8: releasing the reset pin ends low-voltage mode
    assert_lv_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        via_lv_o && mclr_n_i |=> !via_lv_o);
endmodule

bind pe_entry_detect pe_entry_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hv_detect_i   (hv_detect_i),
    .mclr_n_i      (mclr_n_i),
    .prog_active_o (prog_active_o),
    .via_hv_o      (via_hv_o),
    .via_lv_o      (via_lv_o),
    .lv_enable_o   (lv_enable_o)
);

// File: tb/tb_pe_entry_detect.sv
module tb_pe_entry_detect;
    localparam int          CLK_PERIOD = 10;
    localparam int          KB         = 32;
    localparam logic [31:0] KEY        = 32'hA5C3_0F96;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hv = 1'b0, mclr_n = 1'b1, pclk = 1'b0, pdat = 1'b0, lock_req = 1'b0;
    logic active, via_hv, via_lv, lv_en, forced;
    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pe_entry_detect #(.KEY_BITS(KB), .ENTRY_KEY(KEY)) dut (
        .clk(clk), .rst_n(rst_n), .hv_detect_i(hv), .mclr_n_i(mclr_n),
        .pclk_i(pclk), .pdat_i(pdat), .lock_req_i(lock_req),
        .prog_active_o(active), .via_hv_o(via_hv), .via_lv_o(via_lv),
        .lv_enable_o(lv_en), .pin_forced_reset_o(forced)
    );

    // expected outputs packed as {active, via_hv, via_lv, lv_en, forced}
    function automatic logic [4:0] exp_lv(input bit en); return {3'b101, en, 1'b1}; endfunction
    function automatic logic [4:0] exp_hv(input bit en); return {3'b110, en, 1'b0}; endfunction
    function automatic logic [4:0] exp_off(input bit en); return {3'b000, en, 1'b0}; endfunction
    function automatic logic [4:0] exp_after_key(input logic [31:0] k, input bit en);
        return (en && k == KEY) ? exp_lv(en) : exp_off(en);
    endfunction

    task automatic check(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {active, via_hv, via_lv, lv_en, forced};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        pdat = b; pclk = 1'b0; wait_clk(4);
        pclk = 1'b1; wait_clk(4);
        pclk = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] k, input int n);
        for (int i = 0; i < n; i++) send_bit(k[31-i]);
        wait_clk(2);
    endtask

    task automatic pin_low();  mclr_n = 1'b0; wait_clk(3); endtask
    task automatic pin_high(); mclr_n = 1'b1; wait_clk(3); endtask

    initial begin
        wait_clk(100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        check("R1 reset state", exp_off(1'b1));

        // R3 / R9: correct key enters low-voltage mode, pin forced
        pin_low();
        send_bits(KEY, KB);
        check("R3 R9 key entry", exp_after_key(KEY, 1'b1));
        send_bits(32'hFFFF_FFFF, 3);
        check("R3 extra edges ignored in mode", exp_lv(1'b1));
        pin_high();
        check("R8 exit on pin release", exp_off(1'b1));

        // R4: random wrong keys, then the right key without a fresh assertion
        for (int t = 0; t < 4; t++) begin
            logic [31:0] k;
            k = $urandom();
            if (k == KEY) k = ~k;
            pin_low();
            send_bits(k, KB);
            check("R4 wrong key rejected", exp_after_key(k, 1'b1));
            send_bits(KEY, KB);
            check("R4 no retry without fresh reset", exp_off(1'b1));
            pin_high();
        end
        // R4: single bit flips at MSb and LSb
        pin_low(); send_bits(KEY ^ 32'h8000_0000, KB);
        check("R4 MSb flip rejected", exp_off(1'b1)); pin_high();
        pin_low(); send_bits(KEY ^ 32'h0000_0001, KB);
        check("R4 LSb flip rejected", exp_off(1'b1)); pin_high();

        // R5: partial key discarded on release
        for (int t = 0; t < 3; t++) begin
            int n;
            n = 1 + int'($urandom_range(30));
            pin_low();
            send_bits(KEY, n);
            check("R5 partial key inactive", exp_off(1'b1));
            pin_high();
            pin_low();
            send_bits(KEY, KB);
            check("R5 fresh full key enters", exp_lv(1'b1));
            pin_high();
        end
        // R5: 31 bits only, not enough
        pin_low(); send_bits(KEY, KB-1);
        check("R5 one bit short", exp_off(1'b1)); pin_high();

        // R7: lock request outside high-voltage mode ignored
        lock_req = 1'b1; wait_clk(3); lock_req = 1'b0; wait_clk(1);
        check("R7 lock ignored in normal", exp_off(1'b1));

        // R10: high voltage overrides low-voltage mode
        pin_low(); send_bits(KEY, KB);
        hv = 1'b1; wait_clk(2);
        check("R10 hv overrides lv", exp_hv(1'b1));
        hv = 1'b0; wait_clk(1);
        pin_high();
        // R10: high voltage mid-shift
        pin_low(); send_bits(KEY, 10);
        hv = 1'b1; wait_clk(2);
        check("R10 hv during shift", exp_hv(1'b1));
        hv = 1'b0; pin_high();

        // R2 / R8: high-voltage entry and exit
        hv = 1'b1; wait_clk(2);
        check("R2 hv entry", exp_hv(1'b1));
        hv = 1'b0; wait_clk(2);
        check("R8 hv exit", exp_off(1'b1));

        // R7: lockout in high-voltage mode
        hv = 1'b1; wait_clk(2);
        lock_req = 1'b1; wait_clk(1); lock_req = 1'b0; wait_clk(1);
        check("R7 lock clears enable in hv", exp_hv(1'b0));
        hv = 1'b0; wait_clk(2);
        check("R7 enable stays clear", exp_off(1'b0));

        // R6: key no longer accepted
        pin_low(); send_bits(KEY, KB);
        check("R6 key blocked when disabled", exp_after_key(KEY, 1'b0));
        pin_high();

        // R2: high voltage still works with enable cleared
        hv = 1'b1; wait_clk(2);
        check("R2 hv with enable clear", exp_hv(1'b0));
        hv = 1'b0; wait_clk(2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule